// File: doc/BRIEF.md
# Multi-Digit Seven-Segment Decoder with Leading-Zero Suppression

This block turns a row of BCD digits into segment patterns for common-cathode seven-segment displays, where a lit segment is driven high. Each digit position has its own decode stage. The stages pass a "still blanking" flag from the most significant digit toward the least significant one. A zero is dark only while every digit above it is also a dark zero. Once a non-zero digit appears, every zero after it is shown.

Each position also has two override inputs. A lamp-test input lights all seven segments of that digit. A forced-blank input darkens that digit. The least significant digit never takes part in leading-zero suppression, so a row whose value is zero still shows one `0`. Segment outputs and blank flags are registered, so the outputs reflect the inputs that were present at the previous rising clock edge.

Top module: `segdec_row`

## Requirements
- R1: Digit i takes its code from `bcd_in[4*i+3:4*i]` and drives `seg_out[7*i+6:7*i]` as {g,f,e,d,c,b,a}, with segment a in bit 0 and active high. When the digit is neither overridden nor suppressed, codes 0 to 9 give these hexadecimal patterns in order: 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R2: Codes 10 to 15 give all segments off (00) when lamp test is inactive.
- R3: When `lamp_test[i]` is high, digit i shows 7F, whatever its code, its forced-blank input or its suppression state.
- R4: When `force_blank[i]` is high and `lamp_test[i]` is low, digit i shows 00.
- R5: `rbo_out[i]` is high exactly when the digit's blank-in is high and its code is 0, independent of lamp test and forced blank. The blank-in of digit i is `rbo_out` of digit i+1. The blank-in of the most significant digit (index NUM_DIGITS-1) is always high. A suppressed digit shows 00.
- R6: Leading zeros are dark. A zero below any non-zero digit is shown as 3F.
- R7: The blank-in of digit 0 is always low, so digit 0 shows 3F for code 0 and `rbo_out[0]` is always low.
- R8: While `rst_n` is low, all outputs are 0. Otherwise the outputs change only at a rising clock edge, to the values computed from the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bcd_in | input | 4*NUM_DIGITS | Packed BCD digits, digit 0 least significant |
| lamp_test | input | NUM_DIGITS | Per-digit all-segments-on override |
| force_blank | input | NUM_DIGITS | Per-digit all-segments-off override |
| seg_out | output | 7*NUM_DIGITS | Registered segment patterns {g..a} per digit |
| rbo_out | output | NUM_DIGITS | Registered blank-out flag of each digit |

## Verification
A broken link in the blank chain shows at the ports as `rbo_out` bits that are not monotone from the most significant digit down. It also shows as a zero that is lit or dark in the wrong place. Either appears on the clock edge after the offending digit pattern is applied. Because every output is registered directly from combinational decode, any wrong value is visible one cycle after the stimulus and never later. The random patterns are weighted toward zeros so that runs of leading zeros and interior zeros of every length occur, together with sparse override bits.

// File: rtl/segdec_pkg.sv
package segdec_pkg;
    localparam int SEG_W = 7;
    localparam int BCD_W = 4;

    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [BCD_W-1:0] bcd_t;

    localparam seg_t SEG_ALL_ON  = 7'h7F;
    localparam seg_t SEG_ALL_OFF = 7'h00;
endpackage

// File: rtl/segdec_bcd_decode.sv
module segdec_bcd_decode
    import segdec_pkg::*;
(
    input  bcd_t code_i,
    output seg_t seg_o
);
    always_comb begin
        unique case (code_i)
            4'd0:    seg_o = 7'h3F;
            4'd1:    seg_o = 7'h06;
            4'd2:    seg_o = 7'h5B;
            4'd3:    seg_o = 7'h4F;
            4'd4:    seg_o = 7'h66;
            4'd5:    seg_o = 7'h6D;
            4'd6:    seg_o = 7'h7D;
            4'd7:    seg_o = 7'h07;
            4'd8:    seg_o = 7'h7F;
            4'd9:    seg_o = 7'h6F;
            default: seg_o = SEG_ALL_OFF;
        endcase
    end
endmodule

// File: rtl/segdec_stage.sv
module segdec_stage
    import segdec_pkg::*;
(
    input  bcd_t code_i,
    input  logic blank_in_i,
    input  logic lamp_i,
    input  logic kill_i,
    output seg_t seg_o,
    output logic blank_out_o
);
    seg_t glyph;
    logic is_zero;
    logic suppress;

    segdec_bcd_decode dec_i (
        .code_i (code_i),
        .seg_o  (glyph)
    );

    assign is_zero     = (code_i == '0);
    assign suppress    = blank_in_i & is_zero;
    assign blank_out_o = suppress;

    // Priority: lamp test, then forced blank, then ripple suppression.
    always_comb begin
        if (lamp_i)
            seg_o = SEG_ALL_ON;
        else if (kill_i || suppress)
            seg_o = SEG_ALL_OFF;
        else
            seg_o = glyph;
    end
endmodule

// File: rtl/segdec_row.sv
module segdec_row
    import segdec_pkg::*;
#(
    parameter int NUM_DIGITS = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_DIGITS*BCD_W-1:0] bcd_in,
    input  logic [NUM_DIGITS-1:0]       lamp_test,
    input  logic [NUM_DIGITS-1:0]       force_blank,
    output logic [NUM_DIGITS*SEG_W-1:0] seg_out,
    output logic [NUM_DIGITS-1:0]       rbo_out
);
    localparam int MSD = NUM_DIGITS - 1;

    typedef struct packed {
        logic [NUM_DIGITS*SEG_W-1:0] seg;
        logic [NUM_DIGITS-1:0]       rbo;
    } row_state_t;

    row_state_t state_d, state_q;
    logic [NUM_DIGITS-1:0]       blank_in;
    logic [NUM_DIGITS-1:0]       blank_out;
    logic [NUM_DIGITS*SEG_W-1:0] seg_comb;

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_stage
        if (i == 0) begin : g_lsd
            assign blank_in[i] = 1'b0;
        end else if (i == MSD) begin : g_msd
            assign blank_in[i] = 1'b1;
        end else begin : g_mid
            assign blank_in[i] = blank_out[i+1];
        end

        segdec_stage stage_i (
            .code_i      (bcd_in[i*BCD_W +: BCD_W]),
            .blank_in_i  (blank_in[i]),
            .lamp_i      (lamp_test[i]),
            .kill_i      (force_blank[i]),
            .seg_o       (seg_comb[i*SEG_W +: SEG_W]),
            .blank_out_o (blank_out[i])
        );
    end

    always_comb begin
        state_d     = state_q;
        state_d.seg = seg_comb;
        state_d.rbo = blank_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign seg_out = state_q.seg;
    assign rbo_out = state_q.rbo;
endmodule

// File: rtl/segdec_row_checker.sv
module segdec_row_checker
    import segdec_pkg::*;
#(
    parameter int NUM_DIGITS = 5
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_DIGITS*BCD_W-1:0] bcd_in,
    input logic [NUM_DIGITS-1:0]       lamp_test,
    input logic [NUM_DIGITS-1:0]       force_blank,
    input logic [NUM_DIGITS*SEG_W-1:0] seg_out,
    input logic [NUM_DIGITS-1:0]       rbo_out
);
    // R8: reset clears every output
    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (seg_out == '0 && rbo_out == '0));

    // R7: least significant digit never reports suppression
    assert_lsd_no_rbo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rbo_out[0]);

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_chk
        // R3: lamp test lights all segments
        assert_lamp_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
            lamp_test[i] |=> seg_out[i*SEG_W +: SEG_W] == 7'h7F);

        // R4: forced blank darkens the digit
        assert_kill_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!lamp_test[i] && force_blank[i]) |=> seg_out[i*SEG_W +: SEG_W] == 7'h00);

        // R2: non-decimal codes show nothing
        assert_bad_code_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!lamp_test[i] && bcd_in[i*BCD_W +: BCD_W] > 4'd9)
            |=> seg_out[i*SEG_W +: SEG_W] == 7'h00);

        // R5: suppression only for a zero code
        assert_rbo_needs_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (bcd_in[i*BCD_W +: BCD_W] != 4'd0) |=> !rbo_out[i]);

        if (i < NUM_DIGITS - 1) begin : g_chain
            // R5: a suppressed digit implies all higher digits were suppressed
            assert_rbo_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
                rbo_out[i] |-> rbo_out[i+1]);
        end
    end
endmodule

bind segdec_row segdec_row_checker #(.NUM_DIGITS(NUM_DIGITS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bcd_in      (bcd_in),
    .lamp_test   (lamp_test),
    .force_blank (force_blank),
    .seg_out     (seg_out),
    .rbo_out     (rbo_out)
);

// File: tb/segdec_row_tb_top.sv
module segdec_row_tb_top;
    localparam int ND = 5;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [ND*4-1:0] bcd_in;
    logic [ND-1:0]   lamp_test;
    logic [ND-1:0]   force_blank;
    logic [ND*7-1:0] seg_out;
    logic [ND-1:0]   rbo_out;

    int n_tests = 0;
    int n_fail  = 0;
    logic [ND*7-1:0] prev_seg = '0;
    logic [ND-1:0]   prev_rbo = '0;

    always #2.5 clk = ~clk;

    segdec_row #(.NUM_DIGITS(ND)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bcd_in      (bcd_in),
        .lamp_test   (lamp_test),
        .force_blank (force_blank),
        .seg_out     (seg_out),
        .rbo_out     (rbo_out)
    );

    function automatic logic [6:0] glyph(input logic [3:0] c);
        case (c)
            4'd0: return 7'h3F;  4'd1: return 7'h06;
            4'd2: return 7'h5B;  4'd3: return 7'h4F;
            4'd4: return 7'h66;  4'd5: return 7'h6D;
            4'd6: return 7'h7D;  4'd7: return 7'h07;
            4'd8: return 7'h7F;  4'd9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    // Expected segments and blank flags, walking from the top digit down.
    function automatic void model(input logic [ND*4-1:0] b, input logic [ND-1:0] lt,
                                  input logic [ND-1:0] fb,
                                  output logic [ND*7-1:0] s, output logic [ND-1:0] r);
        logic blanking = 1'b1;
        for (int i = ND - 1; i >= 0; i--) begin
            logic [3:0] c = b[i*4 +: 4];
            logic sup = (i != 0) && blanking && (c == 4'd0);
            r[i] = sup;
            blanking = sup;
            if (lt[i])                s[i*7 +: 7] = 7'h7F;
            else if (fb[i] || sup)    s[i*7 +: 7] = 7'h00;
            else                      s[i*7 +: 7] = glyph(c);
        end
    endfunction

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [ND*4-1:0] b, input logic [ND-1:0] lt,
                         input logic [ND-1:0] fb, input string tag);
        logic [ND*7-1:0] es;
        logic [ND-1:0]   er;
        bcd_in = b; lamp_test = lt; force_blank = fb;
        model(b, lt, fb, es, er);
        #1;
        check({29'd0, seg_out}, {29'd0, prev_seg}, "R8 hold before edge");
        @(negedge clk);
        check({29'd0, seg_out}, {29'd0, es}, tag);
        check({59'd0, rbo_out}, {59'd0, er}, "R5 rbo");
        prev_seg = es;
        prev_rbo = er;
    endtask

    initial begin
        #(5 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EC0DE));
        rst_n = 1'b0; bcd_in = '0; lamp_test = '0; force_blank = '0;
        repeat (3) @(negedge clk);
        check({29'd0, seg_out}, 64'd0, "R8 reset seg");
        check({59'd0, rbo_out}, 64'd0, "R8 reset rbo");
        rst_n = 1'b1;

        apply(20'h00000, '0, '0, "R7 all zero shows one 0");
        apply(20'h01234, '0, '0, "R1 digits 1..4");
        apply(20'h56789, '0, '0, "R1 digits 5..9");
        apply(20'h00500, '0, '0, "R6 leading blank trailing zeros shown");
        apply(20'h10203, '0, '0, "R6 interior zeros shown");
        apply(20'hABCDE, '0, '0, "R2 codes 10..14");
        apply(20'hF00F0, '0, '0, "R2 code 15");
        apply(20'h00042, 5'b10000, '0, "R3 lamp on suppressed digit");
        apply(20'h12345, 5'b11111, 5'b11111, "R3 lamp over forced blank");
        apply(20'h98765, '0, 5'b01010, "R4 forced blank");
        apply(20'h00070, '0, 5'b11000, "R4 forced blank on suppressed zeros");
        apply(20'h00000, 5'b00001, 5'b00010, "R7 lsd lamp with zeros");

        for (int k = 0; k < 400; k++) begin
            logic [ND*4-1:0] b;
            logic [ND-1:0]   lt, fb;
            for (int d = 0; d < ND; d++) begin
                int r = $urandom % 20;
                b[d*4 +: 4] = (r < 8) ? 4'd0 : (r < 18) ? 4'(r - 8) : 4'($urandom % 16);
                lt[d] = ($urandom % 12) == 0;
                fb[d] = ($urandom % 10) == 0;
            end
            apply(b, lt, fb, "R1 R6 random pattern");
        end

        rst_n = 1'b0;
        #1;
        check({29'd0, seg_out}, 64'd0, "R8 async reset seg");
        @(negedge clk);
        check({59'd0, rbo_out}, 64'd0, "R8 async reset rbo");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule